// File: doc/BRIEF.md
# APB Level Interrupt Aggregator

This block gathers a parameterised number of level-sensitive interrupt sources, from 2 up to 64, behind an APB slave. Each source has an enable bit and a mask bit. Each set of bits is split into a lower and an upper 32-bit register. A source shows in the final-status view only while its input is high, its enable bit is 1 and its mask bit is 0. The final-status view is a live combinational image of the inputs and holds no state. All final-status bits are ORed together and registered once to form the single interrupt line sent to a parent controller.

Enable and mask flip-flops are built only for the sources that exist. Bits above the source count ignore writes and read as zero. Software can therefore learn the source count: it writes all ones to both enable registers and finds the highest bit that reads back set. To service the sources, software reads the final-status registers and walks the set bits from the lowest upward.

Top module: `irq_gather_apb`

## Requirements
- R1: After reset both enable registers and both mask registers read 0, and `irqOut` is 0.
- R2: Enable bits are written and read at offset 0x00 (sources 0..31) and offset 0x04 (sources 32..63). Bit k of each word maps to source k or source 32+k.
- R3: Enable and mask bits at positions at or above `NUM_SRC` ignore writes and read 0. With `NUM_SRC`=40, writing 0xFFFFFFFF to offset 0x04 reads back 0x000000FF.
- R4: Mask bits are at offset 0x08 (sources 0..31) and offset 0x0C (sources 32..63). A mask bit of 1 removes its source from final status; a mask bit of 0 lets it through.
- R5: Final status at offset 0x30 (sources 0..31) and offset 0x34 (sources 32..63) equals source & enable & ~mask. It tracks the current input levels with no latching.
- R6: `irqOut` equals the OR of all final-status bits one clock edge earlier.
- R7: Reads of any other offset return 0. Writes to the final-status offsets or to unmapped offsets change no register.
- R8: `pready` is always 1 and `pslverr` is always 0, so every transfer completes with no wait state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | APB clock |
| rstN | input | 1 | Active-low asynchronous reset |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write when 1 |
| paddr | input | ADDR_W | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data |
| pready | output | 1 | Transfer ready, tied high |
| pslverr | output | 1 | Transfer error, tied low |
| srcIn | input | NUM_SRC | Level interrupt sources |
| irqOut | output | 1 | Combined interrupt to the parent |

## Verification
A corrupted enable or mask bit appears in the same access phase, either in the readback at 0x00 to 0x0C or in the live status at 0x30/0x34. It reaches `irqOut` one edge later. A flip-flop that has been built at or above the source count shows up as soon as the discovery write of all ones is read back. A status path that latches shows up when a status read is made after the input has dropped.

// File: rtl/irqg_pkg.sv
package irqg_pkg;
  localparam int WORD_W = 32;
  localparam int MAX_SRC = 64;

  typedef enum logic [2:0] {
    RD_NONE,
    RD_EN_LO,
    RD_EN_HI,
    RD_MSK_LO,
    RD_MSK_HI,
    RD_ST_LO,
    RD_ST_HI
  } rdSel_e;

  typedef struct packed {
    logic [1:0] wrEn;    // per half: write enable word
    logic [1:0] wrMsk;   // per half: write mask word
    rdSel_e     rdSel;   // readback source for prdata
  } ctrlStrb_t;
endpackage

// File: rtl/irqg_ctrl.sv
module irqg_ctrl
  import irqg_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  output ctrlStrb_t         strb
);
  localparam int WA_W = ADDR_W - 2;
  localparam logic [WA_W-1:0] OFF_EN_LO  = WA_W'(8'h00 >> 2);
  localparam logic [WA_W-1:0] OFF_EN_HI  = WA_W'(8'h04 >> 2);
  localparam logic [WA_W-1:0] OFF_MSK_LO = WA_W'(8'h08 >> 2);
  localparam logic [WA_W-1:0] OFF_MSK_HI = WA_W'(8'h0C >> 2);
  localparam logic [WA_W-1:0] OFF_ST_LO  = WA_W'(8'h30 >> 2);
  localparam logic [WA_W-1:0] OFF_ST_HI  = WA_W'(8'h34 >> 2);

  logic [WA_W-1:0] wordAddr;
  logic            wrAccess;
  logic            rdAccess;

  assign wordAddr = paddr[ADDR_W-1:2];
  assign wrAccess = psel & penable & pwrite;
  assign rdAccess = psel & penable & ~pwrite;

  always_comb begin
    strb       = '0;
    strb.rdSel = RD_NONE;
    if (wrAccess) begin
      unique case (wordAddr)
        OFF_EN_LO:  strb.wrEn[0]  = 1'b1;
        OFF_EN_HI:  strb.wrEn[1]  = 1'b1;
        OFF_MSK_LO: strb.wrMsk[0] = 1'b1;
        OFF_MSK_HI: strb.wrMsk[1] = 1'b1;
        default: ;
      endcase
    end
    if (rdAccess) begin
      unique case (wordAddr)
        OFF_EN_LO:  strb.rdSel = RD_EN_LO;
        OFF_EN_HI:  strb.rdSel = RD_EN_HI;
        OFF_MSK_LO: strb.rdSel = RD_MSK_LO;
        OFF_MSK_HI: strb.rdSel = RD_MSK_HI;
        OFF_ST_LO:  strb.rdSel = RD_ST_LO;
        OFF_ST_HI:  strb.rdSel = RD_ST_HI;
        default:    strb.rdSel = RD_NONE;
      endcase
    end
  end
endmodule

// File: rtl/irqg_dpath.sv
module irqg_dpath
  import irqg_pkg::*;
#(
  parameter int NUM_SRC = 40
) (
  input  logic               clk,
  input  logic               rstN,
  input  ctrlStrb_t          strb,
  input  logic [WORD_W-1:0]  pwdata,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic [WORD_W-1:0]  prdata,
  output logic               irqOut
);
  localparam int HALVES = MAX_SRC / WORD_W;

  logic [MAX_SRC-1:0] enVec;
  logic [MAX_SRC-1:0] mskVec;
  logic [MAX_SRC-1:0] srcPad;
  logic [MAX_SRC-1:0] finalStat;
  logic               anyPend;

  always_comb begin
    srcPad = '0;
    srcPad[NUM_SRC-1:0] = srcIn;
  end

  // Flops exist only for implemented sources; the rest are constant zero.
  for (genvar i = 0; i < MAX_SRC; i++) begin : g_bit
    localparam int HALF = i / WORD_W;
    localparam int POS  = i % WORD_W;
    if (i < NUM_SRC) begin : g_impl
      always_ff @(posedge clk or negedge rstN) begin
        if (!rstN) begin
          enVec[i]  <= 1'b0;
          mskVec[i] <= 1'b0;
        end else begin
          if (strb.wrEn[HALF])  enVec[i]  <= pwdata[POS];
          if (strb.wrMsk[HALF]) mskVec[i] <= pwdata[POS];
        end
      end
    end else begin : g_absent
      assign enVec[i]  = 1'b0;
      assign mskVec[i] = 1'b0;
    end
  end

  assign finalStat = srcPad & enVec & ~mskVec;
  assign anyPend   = |finalStat;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) irqOut <= 1'b0;
    else       irqOut <= anyPend;
  end

  logic [WORD_W-1:0] enW   [HALVES];
  logic [WORD_W-1:0] mskW  [HALVES];
  logic [WORD_W-1:0] statW [HALVES];

  for (genvar h = 0; h < HALVES; h++) begin : g_half
    assign enW[h]   = enVec[h*WORD_W +: WORD_W];
    assign mskW[h]  = mskVec[h*WORD_W +: WORD_W];
    assign statW[h] = finalStat[h*WORD_W +: WORD_W];
  end

  always_comb begin
    unique case (strb.rdSel)
      RD_EN_LO:  prdata = enW[0];
      RD_EN_HI:  prdata = enW[1];
      RD_MSK_LO: prdata = mskW[0];
      RD_MSK_HI: prdata = mskW[1];
      RD_ST_LO:  prdata = statW[0];
      RD_ST_HI:  prdata = statW[1];
      default:   prdata = '0;
    endcase
  end
endmodule

// File: rtl/irq_gather_apb.sv
module irq_gather_apb
  import irqg_pkg::*;
#(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 12
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               psel,
  input  logic               penable,
  input  logic               pwrite,
  input  logic [ADDR_W-1:0]  paddr,
  input  logic [31:0]        pwdata,
  output logic [31:0]        prdata,
  output logic               pready,
  output logic               pslverr,
  input  logic [NUM_SRC-1:0] srcIn,
  output logic               irqOut
);
  ctrlStrb_t strb;

  irqg_ctrl #(.ADDR_W(ADDR_W)) ctrl_i (
    .psel    (psel),
    .penable (penable),
    .pwrite  (pwrite),
    .paddr   (paddr),
    .strb    (strb)
  );

  irqg_dpath #(.NUM_SRC(NUM_SRC)) dpath_i (
    .clk    (clk),
    .rstN   (rstN),
    .strb   (strb),
    .pwdata (pwdata),
    .srcIn  (srcIn),
    .prdata (prdata),
    .irqOut (irqOut)
  );

  assign pready  = 1'b1;
  assign pslverr = 1'b0;
endmodule

// File: rtl/irqg_chk.sv
module irqg_chk #(
  parameter int NUM_SRC = 40,
  parameter int ADDR_W  = 12
) (
  input logic               clk,
  input logic               rstN,
  input logic               psel,
  input logic               penable,
  input logic               pwrite,
  input logic [ADDR_W-1:0]  paddr,
  input logic [31:0]        pwdata,
  input logic [31:0]        prdata,
  input logic               pready,
  input logic               pslverr,
  input logic [NUM_SRC-1:0] srcIn,
  input logic               irqOut
);
  localparam logic [63:0] IMPL = (NUM_SRC >= 64) ? {64{1'b1}}
                                 : ((64'd1 << NUM_SRC) - 64'd1);

  logic [63:0] shEn, shMsk, srcW;
  logic        wrA, rdA, anyPend;
  logic [7:0]  offs;

  assign wrA  = psel & penable & pwrite;
  assign rdA  = psel & penable & ~pwrite;
  assign offs = 8'(paddr & ADDR_W'('hFC));

  // Shadow registers built from bus traffic only.
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      shEn  <= '0;
      shMsk <= '0;
    end else if (wrA && (paddr >> 8) == 0) begin
      case (offs)
        8'h00: shEn[31:0]   <= pwdata & IMPL[31:0];
        8'h04: shEn[63:32]  <= pwdata & IMPL[63:32];
        8'h08: shMsk[31:0]  <= pwdata & IMPL[31:0];
        8'h0C: shMsk[63:32] <= pwdata & IMPL[63:32];
        default: ;
      endcase
    end
  end

  always_comb begin
    srcW = '0;
    srcW[NUM_SRC-1:0] = srcIn;
  end
  assign anyPend = |(srcW & shEn & ~shMsk);

  logic hiAddr;
  assign hiAddr = (paddr >> 8) != 0;

  AST_RESET_IRQ_LOW: assert property (@(posedge clk) disable iff (!rstN) $rose(rstN) |-> !irqOut); // R1
  AST_RD_EN_LO: assert property (@(posedge clk) disable iff (!rstN) (rdA && !hiAddr && offs == 8'h00) |-> prdata == shEn[31:0]); // R2
  AST_RD_EN_HI_ABSENT_ZERO: assert property (@(posedge clk) disable iff (!rstN) (rdA && !hiAddr && offs == 8'h04) |-> (prdata & ~IMPL[63:32]) == 32'h0); // R3
  AST_RD_MSK_HI: assert property (@(posedge clk) disable iff (!rstN) (rdA && !hiAddr && offs == 8'h0C) |-> prdata == shMsk[63:32]); // R4
  AST_RD_STAT_LO: assert property (@(posedge clk) disable iff (!rstN) (rdA && !hiAddr && offs == 8'h30) |-> prdata == (srcW[31:0] & shEn[31:0] & ~shMsk[31:0])); // R5
  AST_IRQ_OR_DELAY: assert property (@(posedge clk) disable iff (!rstN) 1'b1 |=> irqOut == $past(anyPend)); // R6
  AST_RD_UNMAPPED_ZERO: assert property (@(posedge clk) disable iff (!rstN) (rdA && (hiAddr || offs == 8'h10 || offs == 8'h20)) |-> prdata == 32'h0); // R7
  AST_NO_WAIT_NO_ERR: assert property (@(posedge clk) disable iff (!rstN) pready && !pslverr); // R8
endmodule

bind irq_gather_apb irqg_chk #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) chk_i (
  .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
  .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
  .pslverr(pslverr), .srcIn(srcIn), .irqOut(irqOut)
);

// File: tb/irq_gather_apb_tb_top.sv
module irq_gather_apb_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC = 40;
  localparam int ADDR_W = 12;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic psel = 0, penable = 0, pwrite = 0;
  logic [ADDR_W-1:0] paddr = '0;
  logic [31:0] pwdata = '0;
  logic [31:0] prdata;
  logic pready, pslverr, irqOut;
  logic [63:0] srcAll = '0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  irq_gather_apb #(.NUM_SRC(NUM_SRC), .ADDR_W(ADDR_W)) dut_i (
    .clk(clk), .rstN(rstN), .psel(psel), .penable(penable), .pwrite(pwrite),
    .paddr(paddr), .pwdata(pwdata), .prdata(prdata), .pready(pready),
    .pslverr(pslverr), .srcIn(srcAll[NUM_SRC-1:0]), .irqOut(irqOut)
  );

  typedef struct packed {
    logic        wr;
    logic [11:0] addr;
    logic [31:0] data;   // write data, or expected read data
    logic [63:0] src;
    logic [3:0]  req;
  } vec_t;

  localparam int NV = 21;
  localparam vec_t VEC [NV] = '{
    '{1'b1, 12'h000, 32'hFFFF_FFFF, 64'h0, 4'd2},                 // R2
    '{1'b1, 12'h004, 32'hFFFF_FFFF, 64'h0, 4'd2},                 // R2
    '{1'b0, 12'h000, 32'hFFFF_FFFF, 64'h0, 4'd2},                 // R2
    '{1'b0, 12'h004, 32'h0000_00FF, 64'h0, 4'd3},                 // R3 discovery
    '{1'b0, 12'h030, 32'h8000_0001, 64'h12_8000_0001, 4'd5},      // R5
    '{1'b0, 12'h034, 32'h0000_0012, 64'h12_8000_0001, 4'd5},      // R5
    '{1'b1, 12'h008, 32'h0000_0001, 64'h12_8000_0001, 4'd4},      // R4
    '{1'b0, 12'h030, 32'h8000_0000, 64'h12_8000_0001, 4'd4},      // R4
    '{1'b0, 12'h008, 32'h0000_0001, 64'h12_8000_0001, 4'd4},      // R4
    '{1'b1, 12'h00C, 32'hFFFF_FFFF, 64'h12_8000_0001, 4'd4},      // R4
    '{1'b0, 12'h00C, 32'h0000_00FF, 64'h12_8000_0001, 4'd3},      // R3
    '{1'b0, 12'h034, 32'h0000_0000, 64'h12_8000_0001, 4'd4},      // R4
    '{1'b0, 12'h030, 32'h0000_0004, 64'h4, 4'd5},                 // R5 level follows
    '{1'b0, 12'h030, 32'h0000_0000, 64'h0, 4'd5},                 // R5 no latch
    '{1'b0, 12'h010, 32'h0000_0000, 64'h0, 4'd7},                 // R7
    '{1'b1, 12'h030, 32'hFFFF_FFFF, 64'h0, 4'd7},                 // R7
    '{1'b0, 12'h030, 32'h0000_0000, 64'h0, 4'd7},                 // R7
    '{1'b1, 12'h020, 32'h1234_5678, 64'h0, 4'd7},                 // R7
    '{1'b0, 12'h000, 32'hFFFF_FFFF, 64'h0, 4'd7},                 // R7 unchanged
    '{1'b1, 12'h004, 32'h0000_0100, 64'h0, 4'd3},                 // R3
    '{1'b0, 12'h004, 32'h0000_0000, 64'h0, 4'd3}                  // R3
  };

  task automatic check(input int req, input logic [31:0] act, input logic [31:0] exp, input string what);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL R%0d %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic apbWrite(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge clk);
    penable = 1;
    @(negedge clk);
    psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apbRead(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk);
    psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge clk);
    penable = 1;
    #1 d = prdata;
    @(negedge clk);
    psel = 0; penable = 0;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] rd;
    repeat (3) @(negedge clk);
    rstN = 1;

    // R1: reset state
    apbRead(12'h000, rd); check(1, rd, 32'h0, "enable low after reset");
    apbRead(12'h004, rd); check(1, rd, 32'h0, "enable high after reset");
    apbRead(12'h008, rd); check(1, rd, 32'h0, "mask low after reset");
    apbRead(12'h00C, rd); check(1, rd, 32'h0, "mask high after reset");
    check(1, {31'b0, irqOut}, 32'h0, "irqOut after reset");

    // vector table
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      srcAll = VEC[i].src;
      if (VEC[i].wr) apbWrite(VEC[i].addr, VEC[i].data);
      else begin
        apbRead(VEC[i].addr, rd);
        check(int'(VEC[i].req), rd, VEC[i].data, $sformatf("vector %0d", i));
      end
    end

    // R8: handshake during an access
    @(negedge clk);
    psel = 1; paddr = 12'h030;
    @(negedge clk);
    penable = 1; #1;
    check(8, {30'b0, pready, pslverr}, 32'h2, "pready/pslverr");
    @(negedge clk);
    psel = 0; penable = 0;

    // R6: registered OR output
    apbWrite(12'h00C, 32'h0);
    apbWrite(12'h008, 32'h0);
    apbWrite(12'h004, 32'h0000_00FF);
    @(negedge clk);
    srcAll = 64'h8_0000_0000;            // source 35
    #1 check(6, {31'b0, irqOut}, 32'h0, "irqOut not yet (register)");
    @(negedge clk);
    check(6, {31'b0, irqOut}, 32'h1, "irqOut one edge after source");
    apbWrite(12'h00C, 32'h0000_0008);    // mask source 35
    @(negedge clk);
    check(6, {31'b0, irqOut}, 32'h0, "irqOut after masking");
    apbWrite(12'h00C, 32'h0);
    @(negedge clk);
    check(6, {31'b0, irqOut}, 32'h1, "irqOut after unmask");
    srcAll = 64'h0;
    @(negedge clk);
    check(6, {31'b0, irqOut}, 32'h0, "irqOut after source drop");

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule